// File: doc/BRIEF.md
# Serial memory command acceptance checker

This block sits between a serial front end and a memory's write engine. The front end delivers one strobe per serial bit sampled on the rising clock edge, together with the level of the synchronized chip select. From these the block rebuilds bytes and decodes the first byte of each selection as an opcode. It classifies the command as a control command (latch set or latch clear), a write-type command (array write, status write, identification write, lock) or a read-type command (array read, status read, identification read, lock-status read). It then follows the command through its address bytes.

A write-type command's data bytes are passed on to the write engine as they arrive. The engine is told to commit only through a single execute strobe. That strobe is issued when chip select rises exactly on a byte boundary, at least one data byte has been received and the write-enable latch is set. In every other case the command is dropped without a trace. Read-type commands issue array fetches from an incrementing address and hand each fetched byte to the front end. This repeats at every output byte boundary until deselect. A status read returns the latch and busy flags live. While the external write timer reports busy, only a status read is decoded.

Top module: `spi_cmd_acceptor`

## Requirements
- R1: After reset every strobe output and `wel` are 0. A selection counts only after a high-to-low change of `cs_n` is seen, so when `cs_n` is already low at reset release, bits sent before it goes high have no effect.
- R2: Opcode 0x06 sets `wel` and opcode 0x04 clears it. This happens only when `cs_n` rises after exactly one complete byte. A second byte, or a rise that is not on a byte boundary, leaves `wel` unchanged.
- R3: Array write (opcode 0x02) is followed by two address bytes, high byte first, and then n >= 1 data bytes. When `cs_n` rises on a byte boundary with `wel`=1, this gives exactly one `exec_stb` pulse with `exec_kind`=1, `exec_addr` = the low 15 address bits and `exec_count`=n.
- R4: A write whose `cs_n` rise falls inside a byte produces no `exec_stb` and leaves `wel` unchanged.
- R5: A write with no data byte after its address produces no `exec_stb`.
- R6: A write that ends correctly while `wel`=0 produces no `exec_stb`.
- R7: Each data byte of a write-type command appears once on `wr_byte` with a one-cycle `wr_byte_stb`, in arrival order, whether or not the command later executes.
- R8: Status write (0x01) takes no address and executes with `exec_kind`=2 and `exec_addr`=0. Identification write (0x82) and lock (0x8A) take two address bytes and execute with kinds 3 and 4. All three follow the framing and latch rules of R3.
- R9: Array read (0x03), identification read (0x83) and lock-status read (0x8B) take two address bytes. They then fetch through `rd_en`/`rd_addr` with `rd_space` 5, 7 or 8 respectively. The first fetch uses the received address, and each further completed byte while selected fetches the next address, which wraps modulo 2^15. Two cycles after each `rd_en`, `tx_stb` pulses with `tx_byte` equal to the `rd_data` returned one cycle after `rd_en`.
- R10: Status read (0x05) takes no address. After the opcode byte and after every further byte while selected, it outputs `tx_byte` = {`status_upper`, `wel`, `wip`}.
- R11: While `wip`=1 at the opcode byte, every opcode other than 0x05 is ignored. It causes no `exec_stb`, no `wr_byte_stb`, no `rd_en` and no change of `wel`.
- R12: A high-to-low change of `wip` clears `wel`.
- R13: An opcode outside the ones listed is ignored until the next selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Synchronized chip select, low = selected |
| bit_stb | input | 1 | One-cycle strobe for a sampled serial input bit |
| bit_in | input | 1 | Serial input bit value, most significant bit first |
| wip | input | 1 | Busy flag from the external write-cycle timer |
| status_upper | input | 6 | Upper six status bits returned by a status read |
| rd_data | input | 8 | Array byte, valid the cycle after `rd_en` |
| rd_en | output | 1 | Array fetch request |
| rd_addr | output | 15 | Array fetch address |
| rd_space | output | 4 | Space code of the fetch (5, 7, 8) |
| tx_stb | output | 1 | Next output byte is ready |
| tx_byte | output | 8 | Output byte for the front end to shift out |
| wr_byte_stb | output | 1 | A write data byte was received |
| wr_byte | output | 8 | Received write data byte |
| exec_stb | output | 1 | Commit strobe to the write engine |
| exec_kind | output | 4 | Write kind (1 array, 2 status, 3 identification, 4 lock) |
| exec_addr | output | 15 | Start address of the accepted write |
| exec_count | output | 7 | Number of data bytes, saturating at 127 |
| wel | output | 1 | Write-enable latch |

## Verification
Write commands are sent in four framings: correct ones with one, two and three data bytes, a rise three bits into a byte, a frame with an address and no data, and a correct frame with the latch clear. Comparing these tells the byte-boundary test, the data-present test and the latch test apart. The latch opcodes are also sent with a trailing partial byte and with a second byte. Reads start just below the top of the address space, so the fetch sequence must wrap, and all three read spaces are used. Status reads are issued with the latch in both states and while busy. Busy then blocks writes, reads and latch changes, and its falling edge clears the latch.

// File: rtl/cmd_acceptor_pkg.sv
package cmd_acceptor_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_CTRL, ST_RDOUT, ST_SKIP
  } acc_state_e;

  localparam logic [3:0] K_NONE      = 4'd0;
  localparam logic [3:0] K_WR_ARRAY  = 4'd1;
  localparam logic [3:0] K_WR_STATUS = 4'd2;
  localparam logic [3:0] K_WR_ID     = 4'd3;
  localparam logic [3:0] K_LOCK      = 4'd4;
  localparam logic [3:0] K_RD_ARRAY  = 4'd5;
  localparam logic [3:0] K_RD_STATUS = 4'd6;
  localparam logic [3:0] K_RD_ID     = 4'd7;
  localparam logic [3:0] K_RD_LOCK   = 4'd8;
  localparam logic [3:0] K_SET_WEL   = 4'd9;
  localparam logic [3:0] K_CLR_WEL   = 4'd10;

  typedef struct packed {
    logic       valid;
    logic [3:0] kind;
    logic       has_addr;
    logic       is_read;
    logic       is_ctrl;
  } cmd_info_t;

endpackage

// File: rtl/cmd_acceptor_decode.sv
module cmd_acceptor_decode
  import cmd_acceptor_pkg::*;
#(
  parameter logic [7:0] OP_SET_WEL   = 8'h06,
  parameter logic [7:0] OP_CLR_WEL   = 8'h04,
  parameter logic [7:0] OP_RD_STATUS = 8'h05,
  parameter logic [7:0] OP_WR_STATUS = 8'h01,
  parameter logic [7:0] OP_RD_ARRAY  = 8'h03,
  parameter logic [7:0] OP_WR_ARRAY  = 8'h02,
  parameter logic [7:0] OP_RD_ID     = 8'h83,
  parameter logic [7:0] OP_WR_ID     = 8'h82,
  parameter logic [7:0] OP_RD_LOCK   = 8'h8B,
  parameter logic [7:0] OP_LOCK      = 8'h8A
) (
  input  logic [7:0] opcode,
  output cmd_info_t  info
);

  always_comb begin
    info = '0;
    if (opcode == OP_SET_WEL) begin
      info.valid = 1'b1; info.kind = K_SET_WEL; info.is_ctrl = 1'b1;
    end else if (opcode == OP_CLR_WEL) begin
      info.valid = 1'b1; info.kind = K_CLR_WEL; info.is_ctrl = 1'b1;
    end else if (opcode == OP_RD_STATUS) begin
      info.valid = 1'b1; info.kind = K_RD_STATUS; info.is_read = 1'b1;
    end else if (opcode == OP_WR_STATUS) begin
      info.valid = 1'b1; info.kind = K_WR_STATUS;
    end else if (opcode == OP_RD_ARRAY) begin
      info.valid = 1'b1; info.kind = K_RD_ARRAY; info.is_read = 1'b1; info.has_addr = 1'b1;
    end else if (opcode == OP_WR_ARRAY) begin
      info.valid = 1'b1; info.kind = K_WR_ARRAY; info.has_addr = 1'b1;
    end else if (opcode == OP_RD_ID) begin
      info.valid = 1'b1; info.kind = K_RD_ID; info.is_read = 1'b1; info.has_addr = 1'b1;
    end else if (opcode == OP_WR_ID) begin
      info.valid = 1'b1; info.kind = K_WR_ID; info.has_addr = 1'b1;
    end else if (opcode == OP_RD_LOCK) begin
      info.valid = 1'b1; info.kind = K_RD_LOCK; info.is_read = 1'b1; info.has_addr = 1'b1;
    end else if (opcode == OP_LOCK) begin
      info.valid = 1'b1; info.kind = K_LOCK; info.has_addr = 1'b1;
    end
  end

endmodule

// File: rtl/cmd_acceptor_frame.sv
module cmd_acceptor_frame #(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 bit_stb,
  input  logic                 bit_in,
  output logic                 start_stb,
  output logic                 byte_stb,
  output logic [BYTE_BITS-1:0] byte_val,
  output logic                 end_stb,
  output logic                 end_aligned
);

  localparam int BC_W = $clog2(BYTE_BITS);

  logic                 cs_q;
  logic                 sel;
  logic [BC_W-1:0]      bit_cnt;
  logic [BYTE_BITS-1:0] shreg;
  logic                 cs_fall;
  logic [BYTE_BITS-1:0] shreg_nxt;

  assign cs_fall   = cs_q & ~cs_n;
  assign shreg_nxt = {shreg[BYTE_BITS-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q        <= 1'b0;
      sel         <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      start_stb   <= 1'b0;
      byte_stb    <= 1'b0;
      byte_val    <= '0;
      end_stb     <= 1'b0;
      end_aligned <= 1'b0;
    end else begin
      cs_q      <= cs_n;
      start_stb <= 1'b0;
      byte_stb  <= 1'b0;
      end_stb   <= 1'b0;
      if (cs_fall) begin
        sel       <= 1'b1;
        bit_cnt   <= '0;
        start_stb <= 1'b1;
      end else if (sel && cs_n) begin
        sel         <= 1'b0;
        end_stb     <= 1'b1;
        end_aligned <= (bit_cnt == '0);
      end else if (sel && bit_stb) begin
        shreg <= shreg_nxt;
        if (bit_cnt == BC_W'(BYTE_BITS - 1)) begin
          bit_cnt  <= '0;
          byte_stb <= 1'b1;
          byte_val <= shreg_nxt;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_acceptor_stream.sv
module cmd_acceptor_stream #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [3:0]        load_space,
  input  logic              load_status,
  input  logic              advance,
  input  logic [7:0]        status_byte,
  input  logic [7:0]        rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [3:0]        rd_space,
  output logic              tx_stb,
  output logic [7:0]        tx_byte
);

  logic [ADDR_W-1:0] addr_q;
  logic              stat_mode;
  logic              stat_pend;
  logic              fetch_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      stat_mode  <= 1'b0;
      stat_pend  <= 1'b0;
      fetch_pend <= 1'b0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      rd_space   <= '0;
      tx_stb     <= 1'b0;
      tx_byte    <= '0;
    end else begin
      rd_en      <= 1'b0;
      stat_pend  <= 1'b0;
      tx_stb     <= 1'b0;
      fetch_pend <= rd_en;
      if (load) begin
        addr_q    <= load_addr;
        stat_mode <= load_status;
        rd_space  <= load_space;
        if (load_status) begin
          stat_pend <= 1'b1;
        end else begin
          rd_en   <= 1'b1;
          rd_addr <= load_addr;
        end
      end else if (advance) begin
        if (stat_mode) begin
          stat_pend <= 1'b1;
        end else begin
          addr_q  <= addr_q + 1'b1;
          rd_en   <= 1'b1;
          rd_addr <= addr_q + 1'b1;
        end
      end
      if (fetch_pend) begin
        tx_stb  <= 1'b1;
        tx_byte <= rd_data;
      end else if (stat_pend) begin
        tx_stb  <= 1'b1;
        tx_byte <= status_byte;
      end
    end
  end

endmodule

// File: rtl/spi_cmd_acceptor.sv
module spi_cmd_acceptor
  import cmd_acceptor_pkg::*;
#(
  parameter int         ADDR_BYTES   = 2,
  parameter int         ADDR_W       = 15,
  parameter int         PAGE_BYTES   = 64,
  parameter logic [7:0] OP_SET_WEL   = 8'h06,
  parameter logic [7:0] OP_CLR_WEL   = 8'h04,
  parameter logic [7:0] OP_RD_STATUS = 8'h05,
  parameter logic [7:0] OP_WR_STATUS = 8'h01,
  parameter logic [7:0] OP_RD_ARRAY  = 8'h03,
  parameter logic [7:0] OP_WR_ARRAY  = 8'h02,
  parameter logic [7:0] OP_RD_ID     = 8'h83,
  parameter logic [7:0] OP_WR_ID     = 8'h82,
  parameter logic [7:0] OP_RD_LOCK   = 8'h8B,
  parameter logic [7:0] OP_LOCK      = 8'h8A,
  localparam int        CNT_W        = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              wip,
  input  logic [5:0]        status_upper,
  input  logic [7:0]        rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [3:0]        rd_space,
  output logic              tx_stb,
  output logic [7:0]        tx_byte,
  output logic              wr_byte_stb,
  output logic [7:0]        wr_byte,
  output logic              exec_stb,
  output logic [3:0]        exec_kind,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [CNT_W-1:0]  exec_count,
  output logic              wel
);

  localparam int ASH_W  = 8 * ADDR_BYTES;
  localparam int ACNT_W = $clog2(ADDR_BYTES + 1);

  logic       start_stb, byte_stb, end_stb, end_aligned;
  logic [7:0] byte_val;
  cmd_info_t  dinfo;

  cmd_acceptor_frame #(.BYTE_BITS(8)) u_frame (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .start_stb(start_stb), .byte_stb(byte_stb), .byte_val(byte_val),
    .end_stb(end_stb), .end_aligned(end_aligned)
  );

  cmd_acceptor_decode #(
    .OP_SET_WEL(OP_SET_WEL), .OP_CLR_WEL(OP_CLR_WEL),
    .OP_RD_STATUS(OP_RD_STATUS), .OP_WR_STATUS(OP_WR_STATUS),
    .OP_RD_ARRAY(OP_RD_ARRAY), .OP_WR_ARRAY(OP_WR_ARRAY),
    .OP_RD_ID(OP_RD_ID), .OP_WR_ID(OP_WR_ID),
    .OP_RD_LOCK(OP_RD_LOCK), .OP_LOCK(OP_LOCK)
  ) u_decode (
    .opcode(byte_val), .info(dinfo)
  );

  acc_state_e       st;
  cmd_info_t        info_q;
  logic [ASH_W-1:0] addr_sh;
  logic [ACNT_W-1:0] acnt;
  logic [CNT_W-1:0] dcnt;
  logic             wip_q;

  logic              byte_ev, op_ok, last_addr;
  logic [ASH_W-1:0]  addr_full;
  logic              ld, ld_status, nxt;
  logic [ADDR_W-1:0] ld_addr;
  logic [3:0]        ld_space;
  logic [7:0]        status_byte;
  logic              wel_set, wel_clr, wip_fall;

  assign byte_ev   = byte_stb && !start_stb && !end_stb;
  assign op_ok     = dinfo.valid && (!wip || dinfo.kind == K_RD_STATUS);
  assign last_addr = (acnt == ACNT_W'(ADDR_BYTES - 1));
  assign addr_full = ASH_W'({addr_sh, byte_val});

  assign ld = byte_ev &&
              ((st == ST_OPC && op_ok && dinfo.is_read && !dinfo.has_addr) ||
               (st == ST_ADDR && last_addr && info_q.is_read));
  assign ld_status   = (st == ST_OPC);
  assign ld_addr     = (st == ST_OPC) ? '0 : addr_full[ADDR_W-1:0];
  assign ld_space    = (st == ST_OPC) ? dinfo.kind : info_q.kind;
  assign nxt         = byte_ev && (st == ST_RDOUT);
  assign status_byte = {status_upper, wel, wip};

  assign wip_fall = wip_q && !wip;
  assign wel_set  = end_stb && end_aligned && (st == ST_CTRL) && (info_q.kind == K_SET_WEL);
  assign wel_clr  = end_stb && end_aligned && (st == ST_CTRL) && (info_q.kind == K_CLR_WEL);

  cmd_acceptor_stream #(.ADDR_W(ADDR_W)) u_stream (
    .clk(clk), .rst(rst), .load(ld), .load_addr(ld_addr), .load_space(ld_space),
    .load_status(ld_status), .advance(nxt), .status_byte(status_byte),
    .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_space(rd_space),
    .tx_stb(tx_stb), .tx_byte(tx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel   <= 1'b0;
      wip_q <= 1'b0;
    end else begin
      wip_q <= wip;
      if (wip_fall)     wel <= 1'b0;
      else if (wel_set) wel <= 1'b1;
      else if (wel_clr) wel <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      info_q      <= '0;
      addr_sh     <= '0;
      acnt        <= '0;
      dcnt        <= '0;
      exec_stb    <= 1'b0;
      exec_kind   <= K_NONE;
      exec_addr   <= '0;
      exec_count  <= '0;
      wr_byte_stb <= 1'b0;
      wr_byte     <= '0;
    end else begin
      exec_stb    <= 1'b0;
      wr_byte_stb <= 1'b0;
      if (start_stb) begin
        st      <= ST_OPC;
        addr_sh <= '0;
        acnt    <= '0;
        dcnt    <= '0;
      end else if (end_stb) begin
        if (st == ST_DATA && end_aligned && dcnt != '0 && wel) begin
          exec_stb   <= 1'b1;
          exec_kind  <= info_q.kind;
          exec_addr  <= addr_sh[ADDR_W-1:0];
          exec_count <= dcnt;
        end
        st <= ST_IDLE;
      end else if (byte_stb) begin
        unique case (st)
          ST_OPC: begin
            info_q <= dinfo;
            if (!op_ok)              st <= ST_SKIP;
            else if (dinfo.is_ctrl)  st <= ST_CTRL;
            else if (dinfo.has_addr) st <= ST_ADDR;
            else if (dinfo.is_read)  st <= ST_RDOUT;
            else                     st <= ST_DATA;
          end
          ST_ADDR: begin
            addr_sh <= addr_full;
            acnt    <= acnt + 1'b1;
            if (last_addr) st <= info_q.is_read ? ST_RDOUT : ST_DATA;
          end
          ST_DATA: begin
            wr_byte_stb <= 1'b1;
            wr_byte     <= byte_val;
            if (dcnt != {CNT_W{1'b1}}) dcnt <= dcnt + 1'b1;
          end
          ST_CTRL: st <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_cmd_acceptor_chk.sv
module spi_cmd_acceptor_chk #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wip,
  input logic             rd_en,
  input logic [3:0]       rd_space,
  input logic             tx_stb,
  input logic             wr_byte_stb,
  input logic             exec_stb,
  input logic [CNT_W-1:0] exec_count,
  input logic             wel
);

  // R6: an accepted write always sees the latch set
  p_exec_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
    exec_stb |-> wel);

  // R5: an accepted write carries at least one data byte
  p_exec_has_data_r5: assert property (@(posedge clk) disable iff (rst)
    exec_stb |-> exec_count != '0);

  // R9: fetched byte reaches the output two cycles after the request
  p_tx_latency_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 tx_stb);

  // R9: fetch requests name only a read space
  p_rd_space_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_space == 4'd5 || rd_space == 4'd7 || rd_space == 4'd8));

  // R12: busy dropping clears the latch
  p_wel_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |=> !wel);

  // R3: commit, data forwarding and fetch never coincide
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exec_stb, wr_byte_stb, rd_en}));

endmodule

bind spi_cmd_acceptor spi_cmd_acceptor_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wip(wip), .rd_en(rd_en), .rd_space(rd_space),
  .tx_stb(tx_stb), .wr_byte_stb(wr_byte_stb), .exec_stb(exec_stb),
  .exec_count(exec_count), .wel(wel)
);

// File: tb/spi_cmd_acceptor_tb.sv
module spi_cmd_acceptor_tb_top;

  localparam int AW = 15;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b0;
  logic          bit_stb = 1'b0;
  logic          bit_in = 1'b0;
  logic          wip = 1'b0;
  logic [5:0]    status_upper = 6'h2A;
  logic [7:0]    rd_data = 8'h00;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [3:0]    rd_space;
  logic          tx_stb;
  logic [7:0]    tx_byte;
  logic          wr_byte_stb;
  logic [7:0]    wr_byte;
  logic          exec_stb;
  logic [3:0]    exec_kind;
  logic [AW-1:0] exec_addr;
  logic [CW-1:0] exec_count;
  logic          wel;

  always #4 clk = ~clk;

  spi_cmd_acceptor dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .wip(wip), .status_upper(status_upper), .rd_data(rd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_space(rd_space),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .wr_byte_stb(wr_byte_stb), .wr_byte(wr_byte),
    .exec_stb(exec_stb), .exec_kind(exec_kind), .exec_addr(exec_addr),
    .exec_count(exec_count), .wel(wel)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a, input logic [3:0] s);
    return a[7:0] ^ {1'b0, a[14:8]} ^ {s, 4'h0};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr, rd_space);

  int checks = 0;
  int fails = 0;
  int unexp = 0;
  bit done = 1'b0;

  logic [25:0] q_exec[$];
  string       t_exec[$];
  logic [7:0]  q_tx[$];
  string       t_tx[$];
  logic [7:0]  q_wr[$];
  string       t_wr[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (exec_stb) begin
        if (q_exec.size() == 0) begin
          unexp++;
          $display("FAIL unexpected exec kind=%0d addr=%h count=%0d (R4/R5/R6/R11)", exec_kind, exec_addr, exec_count);
        end else begin
          logic [25:0] e; string t;
          e = q_exec.pop_front(); t = t_exec.pop_front();
          checks++;
          if ({exec_kind, exec_addr, exec_count} !== e) begin
            fails++;
            $display("FAIL %s exec actual=%h expected=%h", t, {exec_kind, exec_addr, exec_count}, e);
          end
        end
      end
      if (tx_stb) begin
        if (q_tx.size() == 0) begin
          unexp++;
          $display("FAIL unexpected tx byte %h (R11/R13)", tx_byte);
        end else begin
          logic [7:0] e; string t;
          e = q_tx.pop_front(); t = t_tx.pop_front();
          checks++;
          if (tx_byte !== e) begin
            fails++;
            $display("FAIL %s tx actual=%h expected=%h", t, tx_byte, e);
          end
        end
      end
      if (wr_byte_stb) begin
        if (q_wr.size() == 0) begin
          unexp++;
          $display("FAIL unexpected write byte %h (R7/R11)", wr_byte);
        end else begin
          logic [7:0] e; string t;
          e = q_wr.pop_front(); t = t_wr.pop_front();
          checks++;
          if (wr_byte !== e) begin
            fails++;
            $display("FAIL %s wr_byte actual=%h expected=%h", t, wr_byte, e);
          end
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic exp_exec(input logic [3:0] k, input logic [AW-1:0] a, input logic [CW-1:0] n, input string t);
    q_exec.push_back({k, a, n}); t_exec.push_back(t);
  endtask

  task automatic exp_tx(input logic [7:0] b, input string t);
    q_tx.push_back(b); t_tx.push_back(t);
  endtask

  task automatic exp_wr(input logic [7:0] b, input string t);
    q_wr.push_back(b); t_wr.push_back(t);
  endtask

  task automatic settle(input string t);
    int u0;
    u0 = unexp;
    repeat (8) @(negedge clk);
    checks++;
    if (q_exec.size() != 0 || q_tx.size() != 0 || q_wr.size() != 0 || unexp != u0) begin
      fails++;
      $display("FAIL %s pending exec=%0d tx=%0d wr=%0d unexpected=%0d expected all 0",
               t, q_exec.size(), q_tx.size(), q_wr.size(), unexp - u0);
    end
    unexp = u0;
  endtask

  task automatic chk_wel(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (wel !== e) begin
      fails++;
      $display("FAIL %s wel actual=%0b expected=%0b", t, wel, e);
    end
  endtask

  task automatic one_byte_cmd(input logic [7:0] op);
    sel(); send_byte(op); desel();
  endtask

  task automatic addr_cmd(input logic [7:0] op, input logic [15:0] a);
    send_byte(op); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (R1) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (exec_stb !== 1'b0 || tx_stb !== 1'b0 || rd_en !== 1'b0 || wr_byte_stb !== 1'b0 || wel !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b expected=00000", {exec_stb, tx_stb, rd_en, wr_byte_stb, wel});
    end
    // R1: cs_n already low at reset release, no falling edge seen
    send_byte(8'h06); desel();
    chk_wel(1'b0, "R1 no selection without falling edge");
    settle("R1");

    // R2: latch set
    one_byte_cmd(8'h06);
    chk_wel(1'b1, "R2 set latch");

    // R3 and R7: array write with three data bytes
    exp_wr(8'hA1, "R7"); exp_wr(8'hB2, "R7"); exp_wr(8'hC3, "R7");
    exp_exec(4'd1, 15'h1234, 7'd3, "R3");
    sel(); addr_cmd(8'h02, 16'h1234); send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3); desel();
    settle("R3");

    // R12: busy pulse clears latch
    @(negedge clk); wip = 1'b1;
    repeat (3) @(negedge clk); wip = 1'b0;
    chk_wel(1'b0, "R12 busy fall clears latch");

    // R4: rise inside a byte
    one_byte_cmd(8'h06);
    exp_wr(8'h11, "R4"); exp_wr(8'h22, "R4");
    sel(); addr_cmd(8'h02, 16'h0040); send_byte(8'h11); send_byte(8'h22);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); desel();
    settle("R4 misaligned write dropped");
    chk_wel(1'b1, "R4 latch kept");

    // R5: no data byte
    sel(); addr_cmd(8'h02, 16'h0100); desel();
    settle("R5 address-only write dropped");

    // R2: latch clear, then R6 write with latch clear
    one_byte_cmd(8'h04);
    chk_wel(1'b0, "R2 clear latch");
    exp_wr(8'h5C, "R6");
    sel(); addr_cmd(8'h02, 16'h0200); send_byte(8'h5C); desel();
    settle("R6 write without latch dropped");

    // R2: malformed latch commands
    sel(); send_byte(8'h06); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); desel();
    chk_wel(1'b0, "R2 partial byte ignored");
    sel(); send_byte(8'h06); send_byte(8'h00); desel();
    chk_wel(1'b0, "R2 second byte ignored");

    // R8: status write, identification write, lock
    one_byte_cmd(8'h06);
    exp_wr(8'h8C, "R8"); exp_exec(4'd2, 15'h0000, 7'd1, "R8 status write");
    sel(); send_byte(8'h01); send_byte(8'h8C); desel();
    settle("R8 status write");
    one_byte_cmd(8'h06);
    exp_wr(8'h01, "R8"); exp_wr(8'h02, "R8"); exp_exec(4'd3, 15'h0010, 7'd2, "R8 id write");
    sel(); addr_cmd(8'h82, 16'h0010); send_byte(8'h01); send_byte(8'h02); desel();
    settle("R8 id write");
    one_byte_cmd(8'h06);
    exp_wr(8'h02, "R8"); exp_exec(4'd4, 15'h0400, 7'd1, "R8 lock");
    sel(); addr_cmd(8'h8A, 16'h0400); send_byte(8'h02); desel();
    settle("R8 lock");

    // R9: array read with wrap
    for (int k = 0; k < 4; k++) exp_tx(pat(15'(15'h7FFE + k), 4'd5), "R9 array read");
    sel(); addr_cmd(8'h03, 16'h7FFE);
    for (int k = 0; k < 3; k++) send_byte(8'hFF);
    repeat (4) @(negedge clk); desel();
    settle("R9 array read");
    exp_tx(pat(15'h0005, 4'd7), "R9 id read"); exp_tx(pat(15'h0006, 4'd7), "R9 id read");
    sel(); addr_cmd(8'h83, 16'h0005); send_byte(8'h00); repeat (4) @(negedge clk); desel();
    settle("R9 id read");
    exp_tx(pat(15'h0000, 4'd8), "R9 lock read");
    sel(); addr_cmd(8'h8B, 16'h0000); repeat (4) @(negedge clk); desel();
    settle("R9 lock read");

    // R10: status read, latch currently clear after lock busy-free? latch still 1
    chk_wel(1'b1, "R10 latch precondition");
    exp_tx({6'h2A, 1'b1, 1'b0}, "R10 status read"); exp_tx({6'h2A, 1'b1, 1'b0}, "R10 status read");
    sel(); send_byte(8'h05); send_byte(8'h00); repeat (4) @(negedge clk); desel();
    settle("R10 status read");

    // R11: busy blocks everything but status read
    @(negedge clk); wip = 1'b1;
    sel(); addr_cmd(8'h02, 16'h0300); send_byte(8'h77); desel();
    settle("R11 write while busy");
    sel(); addr_cmd(8'h03, 16'h0300); send_byte(8'h00); desel();
    settle("R11 read while busy");
    one_byte_cmd(8'h04);
    chk_wel(1'b1, "R11 latch clear ignored while busy");
    status_upper = 6'h15;
    exp_tx({6'h15, 1'b1, 1'b1}, "R11 status read while busy");
    sel(); send_byte(8'h05); repeat (4) @(negedge clk); desel();
    settle("R11 status read while busy");
    @(negedge clk); wip = 1'b0;
    chk_wel(1'b0, "R12 latch cleared at busy end");
    exp_tx({6'h15, 1'b0, 1'b0}, "R10 status after busy");
    sel(); send_byte(8'h05); repeat (4) @(negedge clk); desel();
    settle("R10 status after busy");

    // R13: unknown opcode
    one_byte_cmd(8'h06);
    sel(); send_byte(8'h5A); send_byte(8'h02); send_byte(8'h00); send_byte(8'h01); desel();
    settle("R13 unknown opcode ignored");
    chk_wel(1'b1, "R13 latch kept");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule